// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block keeps one configuration word for each of eight external chip selects and uses them to decide which chip select, if any, owns a 32-bit system address. Each word holds a region base, a size code and an enable bit. A lookup port takes an address and at once returns a one-hot chip-select vector, a flag for an address that no region claims, and the offset of the address inside the region that won.

Software programs the words through a narrow write port and can read any word back through a select-driven read port. Writes are masked to the defined bits. A size code that is not one of the allowed encodings disables the region. The lookup path is purely combinational, so a new word takes part in decoding from the cycle after the write edge. When regions overlap, the lowest-numbered chip select wins.

Top module: `chip_select_decoder`

## Requirements
- R1: After reset, chip select 0 reads back 0xF40 and chip selects 1 to 7 read back 0xF00.
- R2: A write stores the 12-bit word ANDed with 0xF7F in the selected chip select, so bit 7 always reads back 0.
- R3: Word bits 5:0 hold the base, compared with address bits 29:24 at every position the size code keeps. Bit 6 is the enable bit. Bits 11:8 hold the size code, whose ones select which of address bits 27:24 are compared. Bits 29:28 are always compared. An address with bit 31 or bit 30 set never hits.
- R4: Size code 0xF gives a 16 MB region, 0xE a 32 MB region, 0xC a 64 MB region and 0x8 a 128 MB region. Base bits the code leaves uncompared have no effect.
- R5: A chip select whose enable bit (bit 6) is 0 never hits.
- R6: Any size code other than 0x8, 0xC, 0xE or 0xF disables the region. Code 0x0 is a 256 MB region only while full_span_en is 1.
- R7: When several regions hit, only the lowest-numbered chip select shows in the one-hot output (bit i for chip select i).
- R8: When no region hits, miss is 1 and offset is 0; otherwise miss is 0.
- R9: On a hit, offset equals the address ANDed with the winning region's size minus one.
- R10: A write whose bits 11:8 and 6:0 equal the stored word leaves the stored word and every decode result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_span_en | input | 1 | Lets size code 0x0 decode as a 256 MB region |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 3 | Chip select written |
| cfg_wdata | input | 12 | Configuration word to write |
| cfg_rsel | input | 3 | Chip select read back |
| cfg_rdata | output | 12 | Stored configuration word of cfg_rsel |
| lookup_addr | input | 32 | System address to decode |
| cs_hit | output | 8 | One-hot winning chip select |
| cs_miss | output | 1 | No region claims lookup_addr |
| cs_offset | output | 32 | Address offset inside the winning region |

## Verification
A wrong stored word shows on cfg_rdata in the same cycle it is selected. It also moves a region edge, so a lookup at that edge changes cs_hit and cs_offset with no added latency. A wrong size-code check shows as a hit or a miss at one address just beyond a region, and a priority fault shows only where two enabled regions overlap. The directed scenarios therefore probe the first and last byte of each region, an overlap, and the address one past each end.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int CFG_W     = 12;
  localparam int BASE_W    = 6;
  localparam int SIZE_W    = 4;
  localparam int BASE_LSB  = 24;
  localparam logic [CFG_W-1:0] CFG_WMASK = 12'hF7F;

  typedef struct packed {
    logic [SIZE_W-1:0] size_code;
    logic              enable;
    logic [BASE_W-1:0] base;
  } cs_cfg_t;

  function automatic logic [CFG_W-1:0] cfg_to_word(cs_cfg_t c);
    return {c.size_code, 1'b0, c.enable, c.base};
  endfunction

  function automatic cs_cfg_t word_to_cfg(logic [CFG_W-1:0] w);
    cs_cfg_t c;
    c.size_code = w[11:8];
    c.enable    = w[6];
    c.base      = w[5:0];
    return c;
  endfunction

endpackage

// File: rtl/csd_cfg_bank.sv
module csd_cfg_bank
  import csd_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int BOOT_CS   = 0,
  localparam int SEL_W    = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CFG_W-1:0]        wr_word,
  input  logic [SEL_W-1:0]        rd_sel,
  output logic [CFG_W-1:0]        rd_word,
  output cs_cfg_t [NUM_CS-1:0]    cfg_o
);

  cs_cfg_t [NUM_CS-1:0] cfg_q;
  cs_cfg_t [NUM_CS-1:0] cfg_d;
  logic                 differs;
  logic                 upd_en;

  // Only a write that alters a defined bit opens the clock enable.
  always_comb begin
    differs = ((wr_word ^ cfg_to_word(cfg_q[wr_sel])) & CFG_WMASK) != '0;
    upd_en  = wr_en && differs;
    cfg_d   = cfg_q;
    cfg_d[wr_sel] = word_to_cfg(wr_word & CFG_WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        cfg_q[i].size_code <= '1;
        cfg_q[i].enable    <= (i == BOOT_CS);
        cfg_q[i].base      <= '0;
      end
    end else if (upd_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign rd_word = cfg_to_word(cfg_q[rd_sel]);
  assign cfg_o   = cfg_q;

  // R2: the selected word holds the masked write data one cycle later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_to_word(cfg_q[$past(wr_sel)]) == ($past(wr_word) & CFG_WMASK));

  // R10: a write that matches the stored word disturbs nothing
  a_r10_same_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (((wr_word ^ cfg_to_word(cfg_q[wr_sel])) & CFG_WMASK) == '0))
      |=> $stable(cfg_q));

endmodule

// File: rtl/csd_region_match.sv
module csd_region_match
  import csd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  localparam int HI_W     = ADDR_W - BASE_LSB,
  localparam int TOP_W    = HI_W - BASE_W,
  localparam int ZPAD_W   = ADDR_W - BASE_LSB - SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cs_cfg_t           cfg,
  input  logic              full_span_en,
  input  logic [HI_W-1:0]   addr_hi,
  output logic              hit,
  output logic [ADDR_W-1:0] span_mask
);

  logic              code_ok;
  logic [BASE_W-1:0] cmp_mask;
  logic              top_clear;
  logic              base_eq;

  always_comb begin
    unique case (cfg.size_code)
      4'hF, 4'hE, 4'hC, 4'h8: code_ok = 1'b1;
      4'h0:                   code_ok = full_span_en;
      default:                code_ok = 1'b0;
    endcase
    cmp_mask  = {{(BASE_W-SIZE_W){1'b1}}, cfg.size_code};
    top_clear = addr_hi[HI_W-1 -: TOP_W] == '0;
    base_eq   = ((addr_hi[BASE_W-1:0] ^ cfg.base) & cmp_mask) == '0;
    hit       = cfg.enable && code_ok && top_clear && base_eq;
    span_mask = {{ZPAD_W{1'b0}}, ~cfg.size_code, {BASE_LSB{1'b1}}};
  end

  // R5: a disabled chip select never claims an address
  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.enable |-> !hit);

  // R3: addresses above the decoded window are never claimed
  a_r3_window_top: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi[HI_W-1 -: TOP_W] != '0) |-> !hit);

endmodule

// File: rtl/csd_prio_pick.sv
module csd_prio_pick #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CS-1:0]              req,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  span_mask,
  input  logic [ADDR_W-1:0]              addr,
  output logic [NUM_CS-1:0]              grant,
  output logic [ADDR_W-1:0]              offset
);

  // Lowest set bit wins.
  always_comb begin
    grant  = req & ~(req - NUM_CS'(1));
    offset = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (grant[i]) offset = addr & span_mask[i];
    end
  end

  // R7: at most one winner, and it is one of the requesters
  a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R7: any request produces a winner
  a_r7_no_lost_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0));

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csd_pkg::*;
#(
  parameter int NUM_CS  = 8,
  parameter int ADDR_W  = 32,
  parameter int BOOT_CS = 0,
  localparam int SEL_W  = $clog2(NUM_CS),
  localparam int HI_W   = ADDR_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_span_en,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_wsel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsel,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic [NUM_CS-1:0] cs_hit,
  output logic              cs_miss,
  output logic [ADDR_W-1:0] cs_offset
);

  logic                          rst_meta_n;
  logic                          rst_sync_n;
  cs_cfg_t [NUM_CS-1:0]          cfg;
  logic [NUM_CS-1:0]             match;
  logic [NUM_CS-1:0][ADDR_W-1:0] span;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  csd_cfg_bank #(.NUM_CS(NUM_CS), .BOOT_CS(BOOT_CS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_wsel),
    .wr_word (cfg_wdata),
    .rd_sel  (cfg_rsel),
    .rd_word (cfg_rdata),
    .cfg_o   (cfg)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    csd_region_match #(.ADDR_W(ADDR_W)) u_match (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .cfg          (cfg[g]),
      .full_span_en (full_span_en),
      .addr_hi      (lookup_addr[ADDR_W-1 -: HI_W]),
      .hit          (match[g]),
      .span_mask    (span[g])
    );
  end

  csd_prio_pick #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (match),
    .span_mask (span),
    .addr      (lookup_addr),
    .grant     (cs_hit),
    .offset    (cs_offset)
  );

  assign cs_miss = (match == '0);

  // R8: the miss flag and the one-hot output never disagree
  a_r8_miss_consistent: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_miss == (cs_hit == '0));

  // R8: a miss reports a zero offset
  a_r8_miss_zero_offset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_miss |-> (cs_offset == '0));

  // R9: the offset never reaches past the largest region
  a_r9_offset_bounded: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_offset & ~(lookup_addr)) == '0 && cs_offset[ADDR_W-1 -: (HI_W-SIZE_W)] == '0);

endmodule

// File: tb/chip_select_decoder_bench.sv
module chip_select_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        full_span_en;
  logic        cfg_we;
  logic [2:0]  cfg_wsel;
  logic [11:0] cfg_wdata;
  logic [2:0]  cfg_rsel;
  logic [11:0] cfg_rdata;
  logic [31:0] lookup_addr;
  logic [7:0]  cs_hit;
  logic        cs_miss;
  logic [31:0] cs_offset;

  int checks;
  int fails;

  chip_select_decoder u_chip_select_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .full_span_en (full_span_en),
    .cfg_we       (cfg_we),
    .cfg_wsel     (cfg_wsel),
    .cfg_wdata    (cfg_wdata),
    .cfg_rsel     (cfg_rsel),
    .cfg_rdata    (cfg_rdata),
    .lookup_addr  (lookup_addr),
    .cs_hit       (cs_hit),
    .cs_miss      (cs_miss),
    .cs_offset    (cs_offset)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] sel, logic [11:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wsel  = sel;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic read_word(string req, logic [2:0] sel, logic [11:0] exp);
    cfg_rsel = sel;
    #1;
    check(req, {20'd0, cfg_rdata}, {20'd0, exp});
  endtask

  // exp_hit == 0 means a miss is expected, with zero offset.
  task automatic probe(string req, logic [31:0] addr, logic [7:0] exp_hit,
                       logic [31:0] exp_off);
    lookup_addr = addr;
    #1;
    check(req, {24'd0, cs_hit}, {24'd0, exp_hit});
    check(req, {31'd0, cs_miss}, {31'd0, (exp_hit == 8'd0)});
    check(req, cs_offset, exp_off);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state;
    read_word("R1", 3'd0, 12'hF40);
    for (int i = 1; i < 8; i++) read_word("R1", 3'(i), 12'hF00);
    probe("R1 cs0 first byte", 32'h0000_0000, 8'h01, 32'h0);
    probe("R9 cs0 last byte", 32'h00FF_FFFF, 8'h01, 32'h00FF_FFFF);
    probe("R8 past cs0", 32'h0100_0000, 8'h00, 32'h0);
  endtask

  task automatic t_write_mask;
    do_write(3'd1, 12'hFFF);
    read_word("R2 bit7 dropped", 3'd1, 12'hF7F);
    probe("R3 base 0x3F", 32'h3F12_3456, 8'h02, 32'h0012_3456);
    probe("R3 bit30 set", 32'h7F12_3456, 8'h00, 32'h0);
    probe("R3 bit31 set", 32'hBF12_3456, 8'h00, 32'h0);
  endtask

  task automatic t_sizes;
    do_write(3'd2, 12'hE42);
    probe("R4 32MB last", 32'h03FF_FFFF, 8'h04, 32'h01FF_FFFF);
    probe("R4 32MB first", 32'h0200_0000, 8'h04, 32'h0);
    probe("R4 32MB past", 32'h0400_0000, 8'h00, 32'h0);
    do_write(3'd3, 12'hC48);
    probe("R4 64MB", 32'h0BAB_CDEF, 8'h08, 32'h03AB_CDEF);
    probe("R4 64MB past", 32'h0C00_0000, 8'h00, 32'h0);
    do_write(3'd4, 12'h850);
    probe("R4 128MB", 32'h1700_0001, 8'h10, 32'h0700_0001);
    probe("R4 128MB past", 32'h1800_0000, 8'h00, 32'h0);
  endtask

  task automatic t_priority;
    do_write(3'd5, 12'hE41);
    probe("R7 overlap low wins", 32'h0000_0010, 8'h01, 32'h0000_0010);
    probe("R4 uncompared base bit", 32'h0180_0000, 8'h20, 32'h0180_0000);
  endtask

  task automatic t_enable;
    do_write(3'd5, 12'hE01);
    probe("R5 disabled", 32'h0180_0000, 8'h00, 32'h0);
  endtask

  task automatic t_size_codes;
    do_write(3'd6, 12'hA60);
    probe("R6 code 0xA", 32'h2000_0000, 8'h00, 32'h0);
    do_write(3'd6, 12'h060);
    full_span_en = 1'b0;
    probe("R6 code 0 gated", 32'h2FFF_FFFF, 8'h00, 32'h0);
    full_span_en = 1'b1;
    probe("R6 code 0 256MB", 32'h2FFF_FFFF, 8'h40, 32'h0FFF_FFFF);
    probe("R6 code 0 past", 32'h3000_0000, 8'h00, 32'h0);
    full_span_en = 1'b0;
  endtask

  task automatic t_same_write;
    do_write(3'd2, 12'hEC2);
    read_word("R10 word kept", 3'd2, 12'hE42);
    probe("R10 map kept", 32'h03FF_FFFF, 8'h04, 32'h01FF_FFFF);
  endtask

  task automatic t_reset_again;
    do_reset();
    read_word("R1 after rerun", 3'd2, 12'hF00);
    read_word("R1 after rerun", 3'd0, 12'hF40);
    probe("R1 old region gone", 32'h03FF_FFFF, 8'h00, 32'h0);
  endtask

  initial begin
    checks       = 0;
    fails        = 0;
    rst_n        = 1'b0;
    full_span_en = 1'b0;
    cfg_we       = 1'b0;
    cfg_wsel     = '0;
    cfg_wdata    = '0;
    cfg_rsel     = '0;
    lookup_addr  = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write_mask();
    t_sizes();
    t_priority();
    t_enable();
    t_size_codes();
    t_same_write();
    t_reset_again();
    report();
  end

endmodule